// File: doc/BRIEF.md
# Program Counter Fetch Unit

This block keeps the program counter of a single-cycle 32-bit RISC-V processor and hands the fetched instruction word to the decoder. Each rising clock edge picks the next program counter from three choices. A redirect from the execute logic loads a supplied target. A valid fetch with no redirect steps the counter forward by one word. A fetch that is not valid and has no redirect keeps the counter where it is.

The instruction path has no register. While the fetch strobe is high, the word read from instruction memory passes straight through. While the strobe is low, the block drives the canonical no-operation word, so the decoder never acts on stale or undefined data. The program counter register is the only clocked state. Reset is synchronous and loads a nonzero entry address.

Top module: `pcf_fetch_unit`

## Requirements
- R1: A clock edge with `rst_i` high loads `pc_o` with 0x00001000.
- R2: While `insn_valid_i` is low, `insn_o` equals 0x00000013 whatever `insn_rdata_i` carries.
- R3: A clock edge with `redir_i` high and `rst_i` low loads `pc_o` with `redir_target_i`, with bit 0 cleared.
- R4: A clock edge with `insn_valid_i` high, `redir_i` low and `rst_i` low adds 4 to `pc_o`.
- R5: A clock edge with `insn_valid_i` low, `redir_i` low and `rst_i` low leaves `pc_o` unchanged.
- R6: While `insn_valid_i` is high, `insn_o` equals `insn_rdata_i` in the same cycle, with no clock edge in between.
- R7: A redirect is taken even when `insn_valid_i` is low in that cycle.
- R8: Only bit 0 of a redirect target is cleared. A target with bit 1 set keeps bit 1 in `pc_o`.
- R9: Stepping from 0xFFFFFFFC wraps `pc_o` to 0x00000000.
- R10: Reset takes priority over a redirect on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| insn_valid_i | input | 1 | Fetched data on `insn_rdata_i` is valid |
| insn_rdata_i | input | 32 | Raw word read from instruction memory |
| redir_i | input | 1 | Execute logic requests a change of flow |
| redir_target_i | input | 32 | Address to load when `redir_i` is high |
| pc_o | output | 32 | Current instruction address |
| insn_o | output | 32 | Instruction word handed to the decoder |

## Verification
The next-PC choice is driven with every combination of the valid strobe and the redirect flag. This separates stepping, holding and redirecting, and it shows that a redirect does not depend on the strobe. Redirect targets include an odd address and one with only bit 1 set, which show that exactly bit 0 is cleared. A step from the top word of the address space checks the wrap. Reset is asserted together with a redirect to check its priority. On the instruction path, changing the read data while the strobe is low shows that the no-operation word is substituted, and changing it within one high-strobe cycle shows that the data passes through with no register delay.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

    localparam int unsigned XLEN          = 32;
    localparam logic [31:0] ENTRY_DEFAULT = 32'h0000_1000;
    localparam logic [31:0] NOP_DEFAULT   = 32'h0000_0013;
    localparam int unsigned STEP_DEFAULT  = 4;

    // Source of the next program counter value
    typedef enum logic [1:0] {
        NPC_HOLD  = 2'd0,
        NPC_SEQ   = 2'd1,
        NPC_REDIR = 2'd2,
        NPC_ENTRY = 2'd3
    } npc_src_e;

endpackage

// File: rtl/pcf_next_sel.sv
module pcf_next_sel
    import pcf_pkg::*;
#(
    parameter int unsigned    ADDR_W     = XLEN,
    parameter logic [ADDR_W-1:0] ENTRY_ADDR = ADDR_W'(ENTRY_DEFAULT),
    parameter int unsigned    PC_STEP    = STEP_DEFAULT
) (
    input  logic              rst_i,
    input  logic              valid_i,
    input  logic              redir_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [ADDR_W-1:0] pc_q_i,
    output logic [ADDR_W-1:0] pc_d_o
);

    localparam logic [ADDR_W-1:0] STEP_V   = ADDR_W'(PC_STEP);
    localparam logic [ADDR_W-1:0] LSB_MASK = ~ADDR_W'(1);

    npc_src_e src_d;

    // Priority: reset, then redirect, then sequential, else hold
    always_comb begin
        if (rst_i)        src_d = NPC_ENTRY;
        else if (redir_i) src_d = NPC_REDIR;
        else if (valid_i) src_d = NPC_SEQ;
        else              src_d = NPC_HOLD;
    end

    always_comb begin
        unique case (src_d)
            NPC_ENTRY: pc_d_o = ENTRY_ADDR;
            NPC_REDIR: pc_d_o = target_i & LSB_MASK;
            NPC_SEQ:   pc_d_o = pc_q_i + STEP_V;
            default:   pc_d_o = pc_q_i;
        endcase
    end

endmodule

// File: rtl/pcf_insn_gate.sv
module pcf_insn_gate
    import pcf_pkg::*;
#(
    parameter int unsigned       INSN_W   = XLEN,
    parameter logic [INSN_W-1:0] NOP_WORD = INSN_W'(NOP_DEFAULT)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              valid_i,
    input  logic [INSN_W-1:0] rdata_i,
    output logic [INSN_W-1:0] insn_o
);

    always_comb begin
        insn_o = valid_i ? rdata_i : NOP_WORD;
    end

    // R2: invalid fetch shows the no-operation word
    p_nop_on_invalid_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |-> insn_o == NOP_WORD);

    // R6: valid fetch passes the memory data through
    p_pass_on_valid_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i |-> insn_o == rdata_i);

endmodule

// File: rtl/pcf_fetch_unit.sv
module pcf_fetch_unit
    import pcf_pkg::*;
#(
    parameter int unsigned       ADDR_W     = XLEN,
    parameter int unsigned       INSN_W     = XLEN,
    parameter logic [ADDR_W-1:0] ENTRY_ADDR = ADDR_W'(ENTRY_DEFAULT),
    parameter logic [INSN_W-1:0] NOP_WORD   = INSN_W'(NOP_DEFAULT),
    parameter int unsigned       PC_STEP    = STEP_DEFAULT
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              insn_valid_i,
    input  logic [INSN_W-1:0] insn_rdata_i,
    input  logic              redir_i,
    input  logic [ADDR_W-1:0] redir_target_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [INSN_W-1:0] insn_o
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(PC_STEP);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } fetch_state_t;

    fetch_state_t      st_d, st_q;
    logic [ADDR_W-1:0] npc_d;

    pcf_next_sel #(
        .ADDR_W     (ADDR_W),
        .ENTRY_ADDR (ENTRY_ADDR),
        .PC_STEP    (PC_STEP)
    ) i_next_sel (
        .rst_i    (rst_i),
        .valid_i  (insn_valid_i),
        .redir_i  (redir_i),
        .target_i (redir_target_i),
        .pc_q_i   (st_q.pc),
        .pc_d_o   (npc_d)
    );

    pcf_insn_gate #(
        .INSN_W   (INSN_W),
        .NOP_WORD (NOP_WORD)
    ) i_insn_gate (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .valid_i (insn_valid_i),
        .rdata_i (insn_rdata_i),
        .insn_o  (insn_o)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = npc_d;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign pc_o = st_q.pc;

    // R1: first cycle out of reset starts at the entry address
    p_entry_after_reset_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> pc_o == ENTRY_ADDR);

    // R3: redirect loads the target with bit 0 cleared
    p_redirect_load_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        redir_i |=> pc_o == ($past(redir_target_i) & ~ADDR_W'(1)));

    // R4: valid fetch without redirect steps one word
    p_seq_step_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (insn_valid_i && !redir_i) |=> pc_o == $past(pc_o) + STEP_V);

    // R5: invalid fetch without redirect holds
    p_hold_invalid_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!insn_valid_i && !redir_i) |=> $stable(pc_o));

    // R8: bit 0 of the address is never set out of reset
    p_even_pc_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        pc_o[0] == 1'b0);

endmodule

// File: tb/test_pcf_fetch_unit.sv
module test_pcf_fetch_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid;
    logic [31:0] rdata;
    logic        redir;
    logic [31:0] target;
    logic [31:0] pc;
    logic [31:0] insn;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pcf_fetch_unit i_pcf_fetch_unit (
        .clk_i          (clk),
        .rst_i          (rst),
        .insn_valid_i   (valid),
        .insn_rdata_i   (rdata),
        .redir_i        (redir),
        .redir_target_i (target),
        .pc_o           (pc),
        .insn_o         (insn)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, then sample 1 ns after the rising edge
    task automatic cyc(input logic r, input logic v, input logic j,
                       input logic [31:0] t, input logic [31:0] d);
        @(negedge clk);
        rst = r; valid = v; redir = j; target = t; rdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        cyc(1, 0, 0, 32'h0, 32'h0);
        cyc(1, 0, 0, 32'h0, 32'h0);
        chk("R1 reset pc", pc, 32'h0000_1000);
        chk("R2 reset insn", insn, 32'h0000_0013);
    endtask

    task automatic t_seq;
        logic [31:0] exp = pc;
        for (int k = 0; k < 3; k++) begin
            cyc(0, 1, 0, 32'h0, 32'h0A00_0093 + k);
            exp += 4;
            chk("R4 step", pc, exp);
        end
    endtask

    task automatic t_hold;
        logic [31:0] exp = pc;
        cyc(0, 0, 0, 32'hFFFF_0000, 32'hDEAD_BEEF);
        chk("R5 hold", pc, exp);
        chk("R2 nop while invalid", insn, 32'h0000_0013);
        cyc(0, 0, 0, 32'h0, 32'h1234_5678);
        chk("R5 hold twice", pc, exp);
        chk("R2 nop other data", insn, 32'h0000_0013);
    endtask

    task automatic t_pass;
        @(negedge clk);
        valid = 1; redir = 0; rdata = 32'h00A0_2223;
        #1 chk("R6 pass first", insn, 32'h00A0_2223);
        rdata = 32'hFF41_0113;
        #1 chk("R6 pass same cycle", insn, 32'hFF41_0113);
        valid = 0;
        #1 chk("R2 drop to nop", insn, 32'h0000_0013);
        valid = 1;
        @(posedge clk); #1;
    endtask

    task automatic t_jump;
        cyc(0, 1, 1, 32'h0000_2040, 32'h0);
        chk("R3 redirect", pc, 32'h0000_2040);
        cyc(0, 1, 0, 32'h0, 32'h0);
        chk("R4 step after redirect", pc, 32'h0000_2044);
    endtask

    task automatic t_jump_invalid;
        cyc(0, 0, 1, 32'h0000_3000, 32'h0);
        chk("R7 redirect while invalid", pc, 32'h0000_3000);
    endtask

    task automatic t_align;
        cyc(0, 1, 1, 32'h0000_4001, 32'h0);
        chk("R3 odd target bit0 cleared", pc, 32'h0000_4000);
        cyc(0, 1, 1, 32'h0000_5006, 32'h0);
        chk("R8 bit1 kept", pc, 32'h0000_5006);
        cyc(0, 1, 1, 32'h0000_6003, 32'h0);
        chk("R8 only bit0 cleared", pc, 32'h0000_6002);
    endtask

    task automatic t_wrap;
        cyc(0, 1, 1, 32'hFFFF_FFFC, 32'h0);
        chk("R3 top target", pc, 32'hFFFF_FFFC);
        cyc(0, 1, 0, 32'h0, 32'h0);
        chk("R9 wrap", pc, 32'h0000_0000);
    endtask

    task automatic t_reset_prio;
        cyc(0, 1, 1, 32'h0000_7000, 32'h0);
        cyc(1, 1, 1, 32'h0000_8000, 32'h0);
        chk("R10 reset over redirect", pc, 32'h0000_1000);
        cyc(0, 1, 0, 32'h0, 32'h0);
        chk("R1 step from entry", pc, 32'h0000_1004);
    endtask

    initial begin
        rst = 1; valid = 0; redir = 0; target = '0; rdata = '0;
        t_reset();
        t_seq();
        t_hold();
        t_pass();
        t_jump();
        t_jump_invalid();
        t_align();
        t_wrap();
        t_reset_prio();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule